// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Cycle Decoder

This block sits next to an 8-bit processor whose low address byte and data byte share the same eight lines. Early in each bus cycle the processor raises an address-latch strobe while the shared lines hold the low address byte. The block captures that byte and keeps it steady for the rest of the cycle. It joins the byte to the high address byte, which arrives on dedicated lines, to form a 16-bit address.

The block also decodes the processor's three status lines into a machine-cycle code. It splits the shared read, write and interrupt-acknowledge strobes into separate active-low commands for memory and for I/O. A separate flag marks the status lines and command lines as floating, as they are during halt, hold and reset. While that flag is set, the block reports no valid cycle and issues no command.

The shared bidirectional lines appear as separate ports. One input carries what the processor drives. One output carries read data back toward the processor, together with an output-enable. One output carries write data toward the peripherals.

Top module: `bus_demux_decoder`

## Requirements
- R1: While `rst_n` is low, the held low address byte clears to zero. With `ale` low during and after reset, `addr[7:0]` reads 0x00.
- R2: While `ale` is high, `addr[7:0]` follows `ad_in` in the same cycle, as a transparent latch does.
- R3: On the first rising clock edge after `ale` falls, `addr[7:0]` holds the last `ad_in` value that was sampled while `ale` was high. It then stays unchanged, whatever `ad_in` does, until `ale` rises again.
- R4: `addr[15:8]` always equals `a_hi`, with no latching.
- R5: With `stat_float` low, `{io_m,s1,s0}` decodes as follows, and `cyc_valid` is 1 for each of these patterns:
  - 011 gives `cyc_type` 1 (opcode fetch).
  - 010 gives 2 (memory read).
  - 001 gives 3 (memory write).
  - 110 gives 4 (I/O read).
  - 101 gives 5 (I/O write).
  - 111 gives 6 (interrupt acknowledge).
- R6: The patterns 000 and 100 give `cyc_type` 0 with `cyc_valid` 0. When `stat_float` is high, every pattern gives `cyc_type` 0 with `cyc_valid` 0.
- R7: `mem_rd_n` is low exactly when `rd_n` is low, `io_m` is 0, `stat_float` is low and `rst_n` is high. `mem_wr_n` follows the same rule with `wr_n` in place of `rd_n`.
- R8: `io_rd_n` and `io_wr_n` follow the rule of R7, with `io_m` equal to 1 in place of 0.
- R9: `intack_n` is low exactly when `inta_n` is low, `stat_float` is low and `rst_n` is high.
- R10: While `stat_float` is high, all five command outputs stay high and `drv_oe` stays low, for any levels of `rd_n`, `wr_n`, `inta_n` and `io_m`.
- R11: `drv_oe` is high exactly when `mem_rd_n`, `io_rd_n` or `intack_n` is low. `drv_data` equals `rd_data` when `drv_oe` is high and 0x00 otherwise. `wr_data` equals `ad_in` while `mem_wr_n` or `io_wr_n` is low and 0x00 otherwise.
- R12: While `rst_n` is low, all five command outputs are high and `drv_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe, active high |
| ad_in | input | 8 | Shared lines as driven by the processor |
| a_hi | input | 8 | Dedicated high address byte |
| io_m | input | 1 | Status: 1 selects I/O, 0 selects memory |
| s1 | input | 1 | Status bit 1 |
| s0 | input | 1 | Status bit 0 |
| stat_float | input | 1 | High when status and command lines float |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| inta_n | input | 1 | Processor interrupt-acknowledge strobe, active low |
| rd_data | input | 8 | Data returned by the addressed device |
| addr | output | 16 | Full demultiplexed address |
| cyc_type | output | 3 | Machine-cycle code |
| cyc_valid | output | 1 | Cycle code is a defined cycle |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| intack_n | output | 1 | Interrupt-acknowledge command, active low |
| drv_data | output | 8 | Data to place on the shared lines |
| drv_oe | output | 1 | Enable for driving the shared lines |
| wr_data | output | 8 | Write data passed to peripherals |

## Verification
The address path is driven with a strobe pulse followed by a changing data phase on the shared lines. This shows a true hold apart from a plain pass-through. A second pulse with a new byte then shows that the hold releases on each new strobe.

All eight status patterns are swept with the float flag low and then high. The sweep tells the six defined cycles apart from the two undefined ones and from the floating state.

Every combination of `io_m`, the three processor strobes and the float flag is then applied. This separates memory commands from I/O commands, shows that each command depends on its own strobe, and shows that the float flag and reset override everything. Directed read and write phases check the routing of the data path.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;

    // Machine-cycle codes reported on cyc_type
    typedef enum logic [2:0] {
        CYC_NONE   = 3'd0,
        CYC_FETCH  = 3'd1,
        CYC_MEMRD  = 3'd2,
        CYC_MEMWR  = 3'd3,
        CYC_IORD   = 3'd4,
        CYC_IOWR   = 3'd5,
        CYC_INTACK = 3'd6
    } cyc_e;

    localparam int STAT_W = 3;

endpackage

// File: rtl/bd_addr_hold.sv
module bd_addr_hold #(
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ale,
    input  logic [LO_W-1:0] ad_in,
    output logic [LO_W-1:0] lo_view
);

    typedef struct packed {
        logic [LO_W-1:0] lo;
    } hold_t;

    hold_t st_d, st_q;

    // Next-state: capture the shared lines while the strobe is high
    always_comb begin
        st_d = st_q;
        if (ale) begin
            st_d.lo = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Transparent view while the strobe is high, held value afterwards
    assign lo_view = ale ? ad_in : st_q.lo;

endmodule

// File: rtl/bd_cycle_decode.sv
module bd_cycle_decode
    import busdemux_pkg::*;
(
    input  logic io_m,
    input  logic s1,
    input  logic s0,
    input  logic stat_float,
    output cyc_e cyc,
    output logic valid
);

    always_comb begin
        cyc = CYC_NONE;
        if (!stat_float) begin
            unique case ({io_m, s1, s0})
                3'b011:  cyc = CYC_FETCH;
                3'b010:  cyc = CYC_MEMRD;
                3'b001:  cyc = CYC_MEMWR;
                3'b110:  cyc = CYC_IORD;
                3'b101:  cyc = CYC_IOWR;
                3'b111:  cyc = CYC_INTACK;
                default: cyc = CYC_NONE;
            endcase
        end
        valid = (cyc != CYC_NONE);
    end

endmodule

// File: rtl/bd_strobe_gen.sv
module bd_strobe_gen (
    input  logic rst_n,
    input  logic stat_float,
    input  logic io_m,
    input  logic rd_n,
    input  logic wr_n,
    input  logic inta_n,
    output logic mem_rd_n,
    output logic mem_wr_n,
    output logic io_rd_n,
    output logic io_wr_n,
    output logic intack_n
);

    logic qual_ok;
    logic sel_mem;
    logic sel_io;

    always_comb begin
        // Reset or floating status lines block every command
        qual_ok  = rst_n & ~stat_float;
        sel_mem  = qual_ok & ~io_m;
        sel_io   = qual_ok &  io_m;
        mem_rd_n = ~(sel_mem & ~rd_n);
        mem_wr_n = ~(sel_mem & ~wr_n);
        io_rd_n  = ~(sel_io  & ~rd_n);
        io_wr_n  = ~(sel_io  & ~wr_n);
        intack_n = ~(qual_ok & ~inta_n);
    end

endmodule

// File: rtl/bus_demux_decoder.sv
module bus_demux_decoder
    import busdemux_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic [LO_W-1:0]      ad_in,
    input  logic [HI_W-1:0]      a_hi,
    input  logic                 io_m,
    input  logic                 s1,
    input  logic                 s0,
    input  logic                 stat_float,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 inta_n,
    input  logic [LO_W-1:0]      rd_data,
    output logic [LO_W+HI_W-1:0] addr,
    output logic [2:0]           cyc_type,
    output logic                 cyc_valid,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic                 io_rd_n,
    output logic                 io_wr_n,
    output logic                 intack_n,
    output logic [LO_W-1:0]      drv_data,
    output logic                 drv_oe,
    output logic [LO_W-1:0]      wr_data
);

    localparam int ADDR_W = LO_W + HI_W;

    logic [LO_W-1:0] lo_view;
    cyc_e            cyc;
    logic            wr_active;

    bd_addr_hold #(.LO_W(LO_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale     (ale),
        .ad_in   (ad_in),
        .lo_view (lo_view)
    );

    bd_cycle_decode u_dec (
        .io_m       (io_m),
        .s1         (s1),
        .s0         (s0),
        .stat_float (stat_float),
        .cyc        (cyc),
        .valid      (cyc_valid)
    );

    bd_strobe_gen u_stb (
        .rst_n      (rst_n),
        .stat_float (stat_float),
        .io_m       (io_m),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .inta_n     (inta_n),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .io_rd_n    (io_rd_n),
        .io_wr_n    (io_wr_n),
        .intack_n   (intack_n)
    );

    // Full address: dedicated high byte joined to the held low byte
    assign addr[ADDR_W-1:LO_W] = a_hi;
    assign addr[LO_W-1:0]      = lo_view;
    assign cyc_type            = cyc;

    // Data path split of the shared lines
    always_comb begin
        drv_oe    = ~mem_rd_n | ~io_rd_n | ~intack_n;
        wr_active = ~mem_wr_n | ~io_wr_n;
        drv_data  = drv_oe    ? rd_data : '0;
        wr_data   = wr_active ? ad_in   : '0;
    end

endmodule

// File: rtl/bus_demux_decoder_chk.sv
module bus_demux_decoder_chk #(
    parameter int LO_W = 8,
    parameter int HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ale,
    input logic [LO_W-1:0]      ad_in,
    input logic [HI_W-1:0]      a_hi,
    input logic                 stat_float,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 inta_n,
    input logic [LO_W+HI_W-1:0] addr,
    input logic [2:0]           cyc_type,
    input logic                 cyc_valid,
    input logic                 mem_rd_n,
    input logic                 mem_wr_n,
    input logic                 io_rd_n,
    input logic                 io_wr_n,
    input logic                 intack_n,
    input logic                 drv_oe
);

    localparam int ADDR_W = LO_W + HI_W;

    p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> addr[LO_W-1:0] == ad_in);

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ale) && !ale) |-> addr[LO_W-1:0] == $past(ad_in));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ale) && !ale) |-> $stable(addr[LO_W-1:0]));

    p_high_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1:LO_W] == a_hi);

    p_valid_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> cyc_type != 3'd0);

    p_read_needs_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (mem_rd_n && io_rd_n));

    p_write_needs_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |-> (mem_wr_n && io_wr_n));

    p_intack_needs_inta_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inta_n |-> intack_n);

    p_float_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_float |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && intack_n
                        && !drv_oe && !cyc_valid));

    p_oe_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drv_oe |-> (!mem_rd_n || !io_rd_n || !intack_n));

endmodule

bind bus_demux_decoder bus_demux_decoder_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/bus_demux_decoder_tb.sv
`timescale 1ns/1ps
module bus_demux_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  a_hi = 8'h00;
    logic        io_m = 1'b0, s1 = 1'b0, s0 = 1'b0, stat_float = 1'b0;
    logic        rd_n = 1'b1, wr_n = 1'b1, inta_n = 1'b1;
    logic [7:0]  rd_data = 8'h00;
    logic [15:0] addr;
    logic [2:0]  cyc_type;
    logic        cyc_valid, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, intack_n, drv_oe;
    logic [7:0]  drv_data, wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_demux_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
        .io_m(io_m), .s1(s1), .s0(s0), .stat_float(stat_float),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .rd_data(rd_data),
        .addr(addr), .cyc_type(cyc_type), .cyc_valid(cyc_valid),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .intack_n(intack_n), .drv_data(drv_data),
        .drv_oe(drv_oe), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Move to the middle of the low clock phase for driving and sampling
    task automatic step();
        @(negedge clk);
        #5;
    endtask

    function automatic logic [2:0] exp_code(logic m, logic a, logic b, logic f);
        if (f) return 3'd0;
        case ({m, a, b})
            3'b011: return 3'd1;
            3'b010: return 3'd2;
            3'b001: return 3'd3;
            3'b110: return 3'd4;
            3'b101: return 3'd5;
            3'b111: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; ale = 1'b0; ad_in = 8'hA5;
        rd_n = 1'b0; wr_n = 1'b0; inta_n = 1'b0; io_m = 1'b0;
        step();
        chk(addr[7:0] == 8'h00, "R1 low byte clear in reset", addr[7:0], 8'h00);
        chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, intack_n} == 5'b11111,
            "R12 commands idle in reset", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, intack_n}, 5'b11111);
        chk(drv_oe == 1'b0, "R12 no drive in reset", drv_oe, 1'b0);
        io_m = 1'b1;
        #1;
        chk({io_rd_n, io_wr_n} == 2'b11, "R12 io idle in reset", {io_rd_n, io_wr_n}, 2'b11);
        rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1; io_m = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step();
        step();
        chk(addr[7:0] == 8'h00, "R1 low byte zero after reset", addr[7:0], 8'h00);
    endtask

    task automatic t_latch();
        ale = 1'b1; ad_in = 8'h3C;
        #1;
        chk(addr[7:0] == 8'h3C, "R2 transparent while ale high", addr[7:0], 8'h3C);
        ad_in = 8'h4D;
        #1;
        chk(addr[7:0] == 8'h4D, "R2 follows change while ale high", addr[7:0], 8'h4D);
        @(negedge clk);
        ale = 1'b0; ad_in = 8'hE1;
        #5;
        chk(addr[7:0] == 8'h4D, "R3 holds captured byte", addr[7:0], 8'h4D);
        for (int i = 0; i < 4; i++) begin
            step();
            ad_in = 8'(8'h10 + i * 8'h11);
            #1;
            chk(addr[7:0] == 8'h4D, "R3 stable through data phase", addr[7:0], 8'h4D);
        end
        step();
        ale = 1'b1; ad_in = 8'h92;
        @(negedge clk);
        ale = 1'b0; ad_in = 8'h00;
        #5;
        chk(addr[7:0] == 8'h92, "R3 new pulse replaces byte", addr[7:0], 8'h92);
    endtask

    task automatic t_high();
        for (int i = 0; i < 3; i++) begin
            a_hi = 8'(8'h0F << i);
            #1;
            chk(addr[15:8] == a_hi, "R4 high byte passthrough", addr[15:8], a_hi);
        end
    endtask

    task automatic t_decode();
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 8; p++) begin
                stat_float = f[0];
                {io_m, s1, s0} = p[2:0];
                #1;
                chk(cyc_type == exp_code(p[2], p[1], p[0], f[0]),
                    (f == 0 && (p == 0 || p == 4)) ? "R6 undefined pattern" :
                    (f != 0) ? "R6 floating status" : "R5 cycle code",
                    cyc_type, exp_code(p[2], p[1], p[0], f[0]));
                chk(cyc_valid == (exp_code(p[2], p[1], p[0], f[0]) != 3'd0),
                    "R5 R6 valid flag", cyc_valid, exp_code(p[2], p[1], p[0], f[0]) != 3'd0);
            end
        end
        stat_float = 1'b0; {io_m, s1, s0} = 3'b000;
    endtask

    task automatic t_strobes();
        for (int v = 0; v < 32; v++) begin
            logic m, r, w, a, f;
            logic [4:0] e;
            {f, m, r, w, a} = v[4:0];
            io_m = m; rd_n = r; wr_n = w; inta_n = a; stat_float = f;
            #1;
            e[4] = !(!f && !m && !r);
            e[3] = !(!f && !m && !w);
            e[2] = !(!f &&  m && !r);
            e[1] = !(!f &&  m && !w);
            e[0] = !(!f && !a);
            chk({mem_rd_n, mem_wr_n} == e[4:3], f ? "R10 float memory quiet" : "R7 memory commands",
                {mem_rd_n, mem_wr_n}, e[4:3]);
            chk({io_rd_n, io_wr_n} == e[2:1], f ? "R10 float io quiet" : "R8 io commands",
                {io_rd_n, io_wr_n}, e[2:1]);
            chk(intack_n == e[0], f ? "R10 float intack quiet" : "R9 intack command", intack_n, e[0]);
            chk(drv_oe == (!e[4] || !e[2] || !e[0]), "R11 drive enable", drv_oe, (!e[4] || !e[2] || !e[0]));
        end
        io_m = 1'b0; rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1; stat_float = 1'b0;
    endtask

    task automatic t_data();
        rd_data = 8'hC3; ad_in = 8'h5A;
        #1;
        chk(drv_data == 8'h00, "R11 no drive data idle", drv_data, 8'h00);
        chk(wr_data == 8'h00, "R11 no write data idle", wr_data, 8'h00);
        rd_n = 1'b0; io_m = 1'b1;
        #1;
        chk(drv_data == 8'hC3, "R11 read data routed", drv_data, 8'hC3);
        rd_n = 1'b1; wr_n = 1'b0; io_m = 1'b0;
        #1;
        chk(wr_data == 8'h5A, "R11 write data routed", wr_data, 8'h5A);
        chk(drv_data == 8'h00, "R11 no drive during write", drv_data, 8'h00);
        wr_n = 1'b1; inta_n = 1'b0; rd_data = 8'hFF;
        #1;
        chk(drv_data == 8'hFF, "R11 vector driven on acknowledge", drv_data, 8'hFF);
        inta_n = 1'b1;
    endtask

    initial begin
        t_reset();
        step();
        t_latch();
        t_high();
        t_decode();
        t_strobes();
        t_data();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule